// File: doc/BRIEF.md
# JTAG Host Shift Engine

This block is a JTAG master for one target TAP controller. It drives TCK, TMS and TDI and samples TDO. A one-cycle start pulse launches one of four operations, selected by `op_i`. The first forces the TAP into Run-Test/Idle from any state. The next two scan a word through the instruction register or the data register. The last is a fixed identification read that returns the target's 32-bit device code. When an operation finishes, the captured word comes back on `rdata_o`, together with a single-cycle `done_o`.

For a scan, the caller supplies a word, a bit count from 1 to DATA_W, and a shift order (least significant bit first or most significant bit first). Two option bits set where the TAP is left. Without options, the scan exits the shift state, passes through Update and returns to Run-Test/Idle. The no-end option keeps the TAP in the shift state. The no-return option stops the scan in Update. Navigation between TAP states uses fixed TMS preambles, so a scan assumes the TAP starts in Run-Test/Idle.

TCK is derived from the system clock. Each TCK half period lasts `half_period_i + 1` system clocks, and TCK rests high between operations. The instruction register length and the identification opcode are parameters, so the engine fits target variants with 5-bit or 7-bit instruction registers.

The controller has these states:

| State | Role |
|---|---|
| IDLE | Waits for a start pulse. |
| RESET | Nine TCK cycles that force the TAP to Run-Test/Idle. |
| PRE | The TMS preamble that leads into a shift state. |
| SHIFT | One TCK cycle for each data bit. |
| UPDATE | One TCK with TMS high after the shift exit. |
| RETURN | One TCK with TMS low back to Run-Test/Idle. |
| FIN | Publishes the result and pulses done. |

The transitions are:

| From | Condition | To |
|---|---|---|
| IDLE | start, op 0 or 3 | RESET |
| IDLE | start, op 1 or 2 | PRE |
| RESET | op 3 | PRE (instruction register) |
| RESET | otherwise | FIN |
| PRE | always | SHIFT |
| SHIFT | no-end set | FIN |
| SHIFT | otherwise | UPDATE |
| UPDATE | no-return set | FIN |
| UPDATE | otherwise | RETURN |
| RETURN | identification read in its instruction-register phase | PRE (data register) |
| RETURN | otherwise | FIN |
| FIN | always | IDLE |

Each step state moves on only after the rising TCK edge of its last cycle.

Top module: `jtag_host_engine`

## Requirements
- R1: Operation code 0 (TAP reset) gives eight TCK cycles with TMS high, then one with TMS low, which leaves the target TAP in Run-Test/Idle from any state.
- R2: An instruction scan (op code 1) starts with the TMS preamble 1,1,0,0. A data scan (op code 2) starts with 1,0,0. There is one TMS value per TCK cycle and TDI is high during the preamble.
- R3: With `lsb_first_i` = 1, bit 0 of the word leaves on the first data TCK. The TDO value sampled on data edge k (k = 0 first) is returned in bit k of `rdata_o`.
- R4: With `lsb_first_i` = 0, bit n-1 leaves first. The TDO value sampled on data edge k is returned in bit n-1-k.
- R5: A scan shifts exactly `nbits_i` bits, for counts from 1 to 32. Word bits at or above the count never reach TDI and never reach `rdata_o`, and result bits at or above the count read as zero.
- R6: Without options, TMS rises with the last data bit, and then two more TCK cycles follow: one with TMS high (Update) and one with TMS low (Run-Test/Idle). With `no_ret_i` = 1, the low cycle is omitted and the TAP stays in Update.
- R7: With `no_end_i` = 1, TMS stays low through the last data bit and no further TCK cycle follows, so the TAP stays in its shift state.
- R8: TDI is high on every TCK cycle that does not carry a data bit.
- R9: The identification read (op code 3) first performs the R1 sequence. It then shifts the IR_LEN-bit code 0x1E least significant bit first through the instruction register, and then shifts 32 zero bits through the data register. Both scans use the full exit and return. The 32 bits captured during the data scan are returned.
- R10: TCK rests high whenever the engine is not busy. TMS and TDI change only while TCK is low. Each low phase of TCK lasts `half_period_i + 1` system clocks.
- R11: `done_o` is a one-cycle pulse, one system clock after the final rising TCK edge of an operation. `rdata_o` holds the result from that cycle onward, and `busy_o` falls in the same cycle.
- R12: A start pulse is ignored while `busy_o` is high. The running operation continues unchanged, and no extra done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_i | input | 2 | 0 TAP reset, 1 instruction scan, 2 data scan, 3 identification read |
| wdata_i | input | DATA_W | Word to shift out |
| nbits_i | input | LEN_W | Bit count for a scan; 0 counts as 1, values above DATA_W count as DATA_W |
| lsb_first_i | input | 1 | 1 shifts least significant bit first |
| no_end_i | input | 1 | Keep the TAP in the shift state after the last bit |
| no_ret_i | input | 1 | Stop in Update instead of returning to Run-Test/Idle |
| half_period_i | input | DIV_W | TCK half period minus one, in system clocks |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured word |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data toward the target |
| tdo_i | input | 1 | Test data from the target |

## Verification
The bench uses the default parameters: DATA_W = 32, IR_LEN = 5 with opcode 0x1E, and an 8-bit divider. This puts the full 32-bit capture, the 5-bit instruction scan and the longest identification read, 57 TCK cycles, within reach. It drives the half period at 0, 1 and 2 at run time, so both a TCK that toggles every system clock and slower ones are covered, along with the low-phase timing rule. A behavioural TAP state tracker and a TDO pattern indexed by TCK edge let the bench confirm every TMS and TDI value, the final TAP state, and the placement of each captured bit, for counts of 1, 13 and 32.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

    typedef enum logic [1:0] {
        OP_TAPRESET = 2'd0,
        OP_IRSCAN   = 2'd1,
        OP_DRSCAN   = 2'd2,
        OP_IDREAD   = 2'd3
    } jtm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_PRE,
        ST_SHIFT,
        ST_UPDATE,
        ST_RETURN,
        ST_FIN
    } jtm_state_e;

    // TCK cycles with TMS high in the reset walk; one low cycle follows.
    localparam int RESET_HIGH_TCKS = 8;
    // The two preambles have different lengths (index of their last step).
    localparam int PRE_IR_LAST = 3;
    localparam int PRE_DR_LAST = 2;

endpackage

// File: rtl/jtm_tck_div.sv
// Issues one tick per TCK half period while an operation runs.
module jtm_tck_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == '0) begin
            cnt_q <= half_i;
        end else begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

endmodule

// File: rtl/jtm_shift_reg.sv
// Shift register that sends the scan word out and gathers the captured TDO bits,
// in either bit order and over a variable length.
module jtm_shift_reg #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_word_i,
    input  logic [LEN_W-1:0]  load_len_i,
    input  logic              shift_i,
    input  logic              lsb_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              tdo_i,
    output logic              out_bit_o,
    output logic [DATA_W-1:0] word_o
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] nxt;
    logic [IDX_W-1:0]  top_idx;

    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] n);
        logic [DATA_W:0] one_hot;
        one_hot = (DATA_W+1)'(1) << n;
        return one_hot[DATA_W-1:0] - DATA_W'(1);
    endfunction

    assign top_idx   = IDX_W'(len_i - LEN_W'(1));
    assign out_bit_o = lsb_i ? sr_q[0] : sr_q[top_idx];
    assign word_o    = sr_q;

    always_comb begin
        if (lsb_i) begin
            nxt          = sr_q >> 1;
            nxt[top_idx] = tdo_i;
        end else begin
            nxt = ((sr_q << 1) | DATA_W'(tdo_i)) & len_mask(len_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_word_i & len_mask(load_len_i);
        end else if (shift_i) begin
            sr_q <= nxt;
        end
    end

endmodule

// File: rtl/jtag_host_engine.sv
module jtag_host_engine
    import jtm_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                IR_LEN    = 5,
    parameter logic [IR_LEN-1:0] IDCODE_OP = 5'h1E,
    parameter int                DIV_W     = 8,
    localparam int               LEN_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LEN_W-1:0]  nbits_i,
    input  logic              lsb_first_i,
    input  logic              no_end_i,
    input  logic              no_ret_i,
    input  logic [DIV_W-1:0]  half_period_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdi_o,
    input  logic              tdo_i
);

    // The step counter shares the length width; DATA_W >= 8 keeps the reset walk in range.

    jtm_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    jtm_op_e           op_q, op_d;
    logic              lsb_q, lsb_d;
    logic              noend_q, noend_d;
    logic              noret_q, noret_d;
    logic              ir_q, ir_d;
    logic [LEN_W-1:0]  len_q, len_d;
    logic [DIV_W-1:0]  hp_q, hp_d;

    logic              tick, fall, rise, run;
    logic              last_step, step_tms, step_tdi;
    logic              ld, shift_en, sh_out;
    logic [DATA_W-1:0] ld_word, sr_word;

    logic              tck_q, tms_q, tdi_q, done_q;
    logic [DATA_W-1:0] rdata_q;

    function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] n);
        if (n == '0)                    return LEN_W'(1);
        else if (n > LEN_W'(DATA_W))    return LEN_W'(DATA_W);
        else                            return n;
    endfunction

    assign run  = state_q inside {ST_RESET, ST_PRE, ST_SHIFT, ST_UPDATE, ST_RETURN};
    assign fall = tick && tck_q;
    assign rise = tick && !tck_q;

    jtm_tck_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (hp_q),
        .tick_o (tick)
    );

    jtm_shift_reg #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ld),
        .load_word_i (ld_word),
        .load_len_i  (len_d),
        .shift_i     (shift_en),
        .lsb_i       (lsb_q),
        .len_i       (len_q),
        .tdo_i       (tdo_i),
        .out_bit_o   (sh_out),
        .word_o      (sr_word)
    );

    // TMS and TDI values for the current TCK cycle, and whether it is the state's last cycle.
    always_comb begin
        step_tms  = 1'b0;
        last_step = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                step_tms  = cnt_q < LEN_W'(RESET_HIGH_TCKS);
                last_step = cnt_q == LEN_W'(RESET_HIGH_TCKS);
            end
            ST_PRE: begin
                step_tms  = ir_q ? (cnt_q < LEN_W'(2)) : (cnt_q == '0);
                last_step = cnt_q == (ir_q ? LEN_W'(PRE_IR_LAST) : LEN_W'(PRE_DR_LAST));
            end
            ST_SHIFT: begin
                last_step = cnt_q == (len_q - LEN_W'(1));
                step_tms  = last_step && !noend_q;
            end
            ST_UPDATE: begin
                step_tms  = 1'b1;
                last_step = 1'b1;
            end
            ST_RETURN: begin
                step_tms  = 1'b0;
                last_step = 1'b1;
            end
            default: begin
                step_tms  = 1'b0;
                last_step = 1'b0;
            end
        endcase
        step_tdi = (state_q == ST_SHIFT) ? sh_out : 1'b1;
    end

    // Next state and control values.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        op_d     = op_q;
        lsb_d    = lsb_q;
        noend_d  = noend_q;
        noret_d  = noret_q;
        ir_d     = ir_q;
        len_d    = len_q;
        hp_d     = hp_q;
        ld       = 1'b0;
        ld_word  = '0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    op_d    = jtm_op_e'(op_i);
                    hp_d    = half_period_i;
                    cnt_d   = '0;
                    lsb_d   = lsb_first_i;
                    noend_d = no_end_i;
                    noret_d = no_ret_i;
                    len_d   = fit_len(nbits_i);
                    ld      = 1'b1;
                    ld_word = wdata_i;
                    unique case (jtm_op_e'(op_i))
                        OP_IRSCAN: begin
                            ir_d    = 1'b1;
                            state_d = ST_PRE;
                        end
                        OP_DRSCAN: begin
                            ir_d    = 1'b0;
                            state_d = ST_PRE;
                        end
                        default: begin
                            lsb_d   = 1'b1;
                            noend_d = 1'b0;
                            noret_d = 1'b0;
                            state_d = ST_RESET;
                        end
                    endcase
                end
            end
            ST_FIN: state_d = ST_IDLE;
            default: begin
                if (rise) begin
                    shift_en = (state_q == ST_SHIFT);
                    if (!last_step) begin
                        cnt_d = cnt_q + LEN_W'(1);
                    end else begin
                        cnt_d = '0;
                        unique case (state_q)
                            ST_RESET: begin
                                if (op_q == OP_IDREAD) begin
                                    state_d = ST_PRE;
                                    ir_d    = 1'b1;
                                    ld      = 1'b1;
                                    ld_word = DATA_W'(IDCODE_OP);
                                    len_d   = LEN_W'(IR_LEN);
                                end else begin
                                    state_d = ST_FIN;
                                end
                            end
                            ST_PRE:    state_d = ST_SHIFT;
                            ST_SHIFT:  state_d = noend_q ? ST_FIN : ST_UPDATE;
                            ST_UPDATE: state_d = noret_q ? ST_FIN : ST_RETURN;
                            ST_RETURN: begin
                                if (op_q == OP_IDREAD && ir_q) begin
                                    state_d = ST_PRE;
                                    ir_d    = 1'b0;
                                    ld      = 1'b1;
                                    ld_word = '0;
                                    len_d   = LEN_W'(DATA_W);
                                end else begin
                                    state_d = ST_FIN;
                                end
                            end
                            default: state_d = ST_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_TAPRESET;
            lsb_q   <= 1'b1;
            noend_q <= 1'b0;
            noret_q <= 1'b0;
            ir_q    <= 1'b0;
            len_q   <= LEN_W'(1);
            hp_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            lsb_q   <= lsb_d;
            noend_q <= noend_d;
            noret_q <= noret_d;
            ir_q    <= ir_d;
            len_q   <= len_d;
            hp_q    <= hp_d;
        end
    end

    // Pin and result outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck_q   <= 1'b1;
            tms_q   <= 1'b1;
            tdi_q   <= 1'b1;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (fall) begin
                tck_q <= 1'b0;
                tms_q <= step_tms;
                tdi_q <= step_tdi;
            end else if (rise) begin
                tck_q <= 1'b1;
            end
            if (state_q == ST_FIN) begin
                done_q  <= 1'b1;
                rdata_q <= sr_word;
            end
        end
    end

    assign busy_o  = state_q != ST_IDLE;
    assign done_o  = done_q;
    assign rdata_o = rdata_q;
    assign tck_o   = tck_q;
    assign tms_o   = tms_q;
    assign tdi_o   = tdi_q;

endmodule

// File: rtl/jtm_checker.sv
module jtm_checker (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic tck_o,
    input logic tms_o,
    input logic tdi_o
);

    // R10: pins hold steady across a high TCK phase
    a_r10_pins_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

    // R10: TCK rests high when idle
    a_r10_tck_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tck_o);

    // R11: done follows a rising TCK edge by one clock
    a_r11_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(tck_o) && !$past(tck_o, 2)));

    // R11: done lasts a single cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12: an operation ends only through done
    a_r12_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

bind jtag_host_engine jtm_checker u_jtm_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .done_o (done_o),
    .tck_o  (tck_o),
    .tms_o  (tms_o),
    .tdi_o  (tdi_o)
);

// File: tb/tb_jtag_host_engine.sv
module tb_jtag_host_engine;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 6;
    localparam int DIV_W  = 8;

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR, T_UPDR,
        T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPIR
    } tap_e;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        op_i = 2'd0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [LEN_W-1:0]  nbits_i = '0;
    logic              lsb_first_i = 1'b1;
    logic              no_end_i = 1'b0;
    logic              no_ret_i = 1'b0;
    logic [DIV_W-1:0]  half_period_i = '0;
    logic              busy_o, done_o, tck_o, tms_o, tdi_o;
    logic [DATA_W-1:0] rdata_o;
    logic              tdo_i = 1'b0;

    jtag_host_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wdata_i(wdata_i),
        .nbits_i(nbits_i), .lsb_first_i(lsb_first_i), .no_end_i(no_end_i),
        .no_ret_i(no_ret_i), .half_period_i(half_period_i), .busy_o(busy_o),
        .done_o(done_o), .rdata_o(rdata_o), .tck_o(tck_o), .tms_o(tms_o),
        .tdi_o(tdi_o), .tdo_i(tdo_i)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int eidx = 0;
    int cur_hp = 0;
    int lowrun = 0;
    logic prev_tck = 1'b1, prev2_tck = 1'b1;
    logic [63:0] tdo_pat = '0;
    tap_e tap_st = T_TLR;

    // scoreboard queues
    logic [1:0]  e_q[$];     // {tms, tdi} per TCK rising edge
    string       e_tag[$];
    logic        r_care[$];
    logic [31:0] r_data[$];
    tap_e        r_tap[$];
    string       r_tag[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic tap_e tap_next(input tap_e s, input logic m);
        case (s)
            T_TLR:   return m ? T_TLR   : T_RTI;
            T_RTI:   return m ? T_SELDR : T_RTI;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SHDR;
            T_SHDR:  return m ? T_EX1DR : T_SHDR;
            T_EX1DR: return m ? T_UPDR  : T_PAUDR;
            T_PAUDR: return m ? T_EX2DR : T_PAUDR;
            T_EX2DR: return m ? T_UPDR  : T_SHDR;
            T_UPDR:  return m ? T_SELDR : T_RTI;
            T_SELIR: return m ? T_TLR   : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SHIR;
            T_SHIR:  return m ? T_EX1IR : T_SHIR;
            T_EX1IR: return m ? T_UPIR  : T_PAUIR;
            T_PAUIR: return m ? T_EX2IR : T_PAUIR;
            T_EX2IR: return m ? T_UPIR  : T_SHIR;
            default: return m ? T_SELDR : T_RTI;
        endcase
    endfunction

    task automatic push_edge(input logic tms, input logic tdi, input string tag);
        e_q.push_back({tms, tdi});
        e_tag.push_back(tag);
    endtask

    // target side: TDO changes on falling TCK, indexed by edge number
    always @(negedge tck_o) tdo_i = tdo_pat[eidx & 63];

    // edge monitor: TAP tracking and pin comparison at each rising TCK
    always @(posedge tck_o) begin
        if (rst_n) begin
            tap_st = tap_next(tap_st, tms_o);
            eidx++;
            if (e_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected TCK edge", 32'(eidx), 32'd0);
            end else begin
                logic [1:0] ex;
                string      tg;
                ex = e_q.pop_front();
                tg = e_tag.pop_front();
                chk({tms_o, tdi_o} == ex, tg, "tms,tdi", 32'({tms_o, tdi_o}), 32'(ex));
            end
        end
    end

    // result monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!tck_o) begin
                lowrun++;
            end else begin
                if (!prev_tck) chk(lowrun == cur_hp + 1, "R10", "low phase length",
                                   32'(lowrun), 32'(cur_hp + 1));
                lowrun = 0;
            end
            if (done_o) begin
                done_cnt++;
                chk(prev_tck && !prev2_tck, "R11", "done timing", {30'd0, prev2_tck, prev_tck}, 32'd1);
                chk(e_q.size() == 0, "R6", "edges left at done", 32'(e_q.size()), 32'd0);
                chk(!busy_o, "R11", "busy at done", 32'(busy_o), 32'd0);
                if (r_data.size() == 0) begin
                    chk(1'b0, "R12", "unexpected done", 32'd1, 32'd0);
                end else begin
                    logic        c;
                    logic [31:0] d;
                    tap_e        t;
                    string       g;
                    c = r_care.pop_front();
                    d = r_data.pop_front();
                    t = r_tap.pop_front();
                    g = r_tag.pop_front();
                    if (c) chk(rdata_o == d, g, "rdata", rdata_o, d);
                    chk(tap_st == t, g, "tap end state", 32'(tap_st), 32'(t));
                end
            end
            prev2_tck = prev_tck;
            prev_tck  = tck_o;
        end
    end

    // driver: build expectations, then launch the operation
    task automatic run_op(input logic [1:0] op, input logic [31:0] word, input int n,
                          input bit lsb, input bit noend, input bit noret,
                          input int hp, input logic [63:0] pat, input tap_e exp_tap,
                          input string tag, input bit poke);
        logic [31:0] exp;
        int          pre;
        int          d0;
        exp = '0;
        if (op == 2'd0 || op == 2'd3) begin
            for (int i = 0; i < 8; i++) push_edge(1'b1, 1'b1, "R1");
            push_edge(1'b0, 1'b1, "R1");
        end
        if (op == 2'd3) begin
            push_edge(1'b1, 1'b1, "R9"); push_edge(1'b1, 1'b1, "R9");
            push_edge(1'b0, 1'b1, "R9"); push_edge(1'b0, 1'b1, "R9");
            for (int k = 0; k < 5; k++) push_edge(k == 4, 5'h1E >> k, "R9");
            push_edge(1'b1, 1'b1, "R9"); push_edge(1'b0, 1'b1, "R9");
            push_edge(1'b1, 1'b1, "R9"); push_edge(1'b0, 1'b1, "R9"); push_edge(1'b0, 1'b1, "R9");
            for (int k = 0; k < 32; k++) begin
                push_edge(k == 31, 1'b0, "R9");
                exp[k] = pat[23 + k];
            end
            push_edge(1'b1, 1'b1, "R9"); push_edge(1'b0, 1'b1, "R9");
        end
        if (op == 2'd1 || op == 2'd2) begin
            if (op == 2'd1) begin
                pre = 4;
                push_edge(1'b1, 1'b1, "R2"); push_edge(1'b1, 1'b1, "R2");
                push_edge(1'b0, 1'b1, "R2"); push_edge(1'b0, 1'b1, "R2");
            end else begin
                pre = 3;
                push_edge(1'b1, 1'b1, "R2"); push_edge(1'b0, 1'b1, "R2"); push_edge(1'b0, 1'b1, "R2");
            end
            for (int k = 0; k < n; k++) begin
                logic b;
                b = lsb ? word[k] : word[n - 1 - k];
                push_edge((k == n - 1) && !noend, b,
                          (k == n - 1) ? (noend ? "R7" : "R6") : (lsb ? "R3" : "R4"));
                if (lsb) exp[k] = pat[pre + k];
                else     exp[n - 1 - k] = pat[pre + k];
            end
            if (!noend) begin
                push_edge(1'b1, 1'b1, "R8");
                if (!noret) push_edge(1'b0, 1'b1, "R6");
            end
        end
        r_care.push_back(op != 2'd0);
        r_data.push_back(exp);
        r_tap.push_back(exp_tap);
        r_tag.push_back(tag);

        tdo_pat = pat;
        eidx    = 0;
        cur_hp  = hp;
        d0      = done_cnt;
        @(negedge clk);
        start_i       = 1'b1;
        op_i          = op;
        wdata_i       = word;
        nbits_i       = LEN_W'(n);
        lsb_first_i   = lsb;
        no_end_i      = noend;
        no_ret_i      = noret;
        half_period_i = DIV_W'(hp);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R12: second start during busy must be ignored
            repeat (7) @(negedge clk);
            start_i = 1'b1;
            op_i    = 2'd2;
            wdata_i = 32'hFFFF_FFFF;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                chk(tck_o == 1'b1, "R10", "reset tck", 32'(tck_o), 32'd1);
                chk(busy_o == 1'b0, "R11", "reset busy", 32'(busy_o), 32'd0);
                chk(done_o == 1'b0, "R11", "reset done", 32'(done_o), 32'd0);
                chk(tdi_o == 1'b1, "R8", "reset tdi", 32'(tdi_o), 32'd1);

                run_op(2'd0, 32'h0, 1, 1, 0, 0, 0, 64'h0, T_RTI, "R1", 0);
                run_op(2'd3, 32'h0, 1, 1, 0, 0, 2, 64'hC3A5_96E1_7B2D_4F08, T_RTI, "R9", 1);
                run_op(2'd1, 32'h1F, 5, 1, 0, 0, 0, 64'h0000_0000_0000_0150, T_RTI, "R3", 0);
                run_op(2'd1, 32'h08, 5, 0, 0, 0, 1, 64'h0000_0000_0000_0068, T_RTI, "R4", 0);
                run_op(2'd2, 32'hA5C3_0F96, 32, 1, 0, 0, 0, 64'h9E37_79B9_7F4A_7C15, T_RTI, "R3", 0);
                run_op(2'd2, 32'h3C96_E1A7, 32, 0, 0, 0, 0, 64'h5851_F42D_4C95_7F2D, T_RTI, "R4", 0);
                run_op(2'd2, 32'h0000_0001, 1, 1, 0, 0, 0, 64'h0000_0000_0000_0008, T_RTI, "R5", 0);
                run_op(2'd2, 32'hFFFF_E5A3, 13, 1, 0, 0, 0, 64'h1234_5678_9ABC_DEF0, T_RTI, "R5", 0);
                run_op(2'd2, 32'hFFFF_1B2D, 13, 0, 0, 0, 1, 64'h0F1E_2D3C_4B5A_6978, T_RTI, "R5", 0);
                run_op(2'd2, 32'h0000_00B6, 8, 1, 0, 1, 0, 64'h0000_0000_0000_3A40, T_UPDR, "R6", 0);
                run_op(2'd0, 32'h0, 1, 1, 0, 0, 0, 64'h0, T_RTI, "R1", 0);
                run_op(2'd2, 32'h0000_0029, 6, 1, 1, 0, 0, 64'h0000_0000_0000_01C8, T_SHDR, "R7", 0);
                run_op(2'd0, 32'h0, 1, 1, 0, 0, 1, 64'h0, T_RTI, "R1", 0);

                chk(done_cnt == 13, "R12", "done pulse count", 32'(done_cnt), 32'd13);
                chk(e_q.size() == 0, "R12", "edges pending", 32'(e_q.size()), 32'd0);
            end
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL R11 watchdog expired actual=%0d expected=%0d", done_cnt, 13);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule